// File: doc/BRIEF.md
# Link Training Stall Watchdog

This block supervises link bring-up for a serial link controller. Once it is enabled, it samples the controller's debug status at a fixed poll interval. The status has four parts: a 6-bit training state, a link-up flag, an in-training flag and a receiver-valid flag. When the link reports up and is no longer training, the block raises a sticky `link_ok_o`. When no such poll arrives within a bounded number of polls, it raises a sticky `link_fail_o`.

Between polls the block looks for one known stall: the training state machine sits in the recovery receiver-lock state (code 0x0D) while the receiver reports no valid data. When it sees this stall, it drives the receiver data-enable override and the receiver PLL-enable override high together for a fixed hold time, then releases both and resumes polling. Polling stops during the pulse, and the poll that started the pulse does not count toward the failure limit.

The poll interval, the hold time and the poll limit are cycle counts set by parameters. At 100 MHz the defaults give 10 us, 3 ms and 4000 polls. Dropping the enable returns the block to idle at once and clears all outputs.

Top module: `link_train_watchdog`

## Requirements
- R1: While `enable_i` is low, all four outputs are low from the cycle after it is sampled low. This includes aborting a recovery pulse that is in progress.
- R2: The first poll takes place POLL_CYCLES clock edges after the edge that samples `enable_i` high. Later polls follow every POLL_CYCLES edges. Outputs change right after the poll edge.
- R3: A poll with `link_up_i`=1 and `in_training_i`=0 sets `link_ok_o`. This check takes precedence over the stall check.
- R4: A poll that is not a link-up, with `ltssm_state_i`=6'h0D and `rx_valid_i`=0, drives `rx_data_en_ovrd_o` and `rx_pll_en_ovrd_o` high together. The two overrides are always equal.
- R5: A recovery pulse keeps both overrides high for exactly HOLD_CYCLES cycles, then clears them both.
- R6: A poll with `rx_valid_i`=1, or with any training state other than 6'h0D (all six bits compared), takes no recovery action, and polling continues.
- R7: After MAX_POLLS counted polls without link-up, `link_fail_o` is set at the last of those polls.
- R8: Polling pauses during a recovery pulse, and the poll that started the pulse is not counted. After the pulse, the full MAX_POLLS counted polls are still needed to fail, with the first poll POLL_CYCLES edges after the pulse ends.
- R9: `link_ok_o` and `link_fail_o` stay set, whatever the status inputs do, until `enable_i` drops. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Starts and holds supervision; low returns the block to idle |
| ltssm_state_i | input | 6 | Training state code from the controller debug status |
| link_up_i | input | 1 | Link-up flag from debug status |
| in_training_i | input | 1 | Link-in-training flag from debug status |
| rx_valid_i | input | 1 | Receiver-valid flag from the PHY |
| link_ok_o | output | 1 | Sticky: link came up |
| link_fail_o | output | 1 | Sticky: poll limit reached without link-up |
| rx_data_en_ovrd_o | output | 1 | Receiver data-enable override |
| rx_pll_en_ovrd_o | output | 1 | Receiver PLL-enable override |

## Verification
On every cycle the assertions check the following. The two overrides stay equal. A pulse never outlasts the hold time. An override or result flag rises only after matching inputs. The result flags stay exclusive and sticky, and disable clears everything. Only the bench scenarios can show exact poll timing and the full decode of the stall state and flags. They also show that the pulse length is exactly the hold time, and that the stalled poll is left out of the count, which gives the exact cycle in which failure is declared.

// File: rtl/lt_wdg_pkg.sv
package lt_wdg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_POLL = 3'd1,
    ST_HOLD = 3'd2,
    ST_OK   = 3'd3,
    ST_FAIL = 3'd4
  } wdg_state_e;

  localparam logic [5:0] RCVR_LOCK_CODE = 6'h0D;
endpackage

// File: rtl/lt_wdg_span.sv
// Interval timer: counts while run_i, done_o on the LIMIT-th cycle.
module lt_wdg_span #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(LIMIT - 1));
  assign done_o = run_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || at_end)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lt_wdg_poll_cnt.sv
// Counts polls that ended with neither link-up nor stall.
module lt_wdg_poll_cnt #(
  parameter int unsigned MAX_POLLS = 4000,
  localparam int unsigned PW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [PW-1:0] cnt_q;

  assign last_o = (cnt_q == PW'(MAX_POLLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lt_wdg_fsm.sv
module lt_wdg_fsm
  import lt_wdg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       poll_tick_i,
  input  logic       hold_done_i,
  input  logic       link_good_i,
  input  logic       stall_i,
  input  logic       last_poll_i,
  output wdg_state_e state_o,
  output logic       poll_inc_o
);
  wdg_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    poll_inc_o = 1'b0;
    if (!enable_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_POLL;
        ST_POLL: if (poll_tick_i) begin
          if (link_good_i)      state_d = ST_OK;
          else if (stall_i)     state_d = ST_HOLD;
          else if (last_poll_i) state_d = ST_FAIL;
          else                  poll_inc_o = 1'b1;
        end
        ST_HOLD: if (hold_done_i) state_d = ST_POLL;
        ST_OK, ST_FAIL: state_d = state_q;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/link_train_watchdog.sv
module link_train_watchdog
  import lt_wdg_pkg::*;
#(
  parameter int unsigned POLL_CYCLES = 1000,
  parameter int unsigned HOLD_CYCLES = 300000,
  parameter int unsigned MAX_POLLS   = 4000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic [5:0] ltssm_state_i,
  input  logic       link_up_i,
  input  logic       in_training_i,
  input  logic       rx_valid_i,
  output logic       link_ok_o,
  output logic       link_fail_o,
  output logic       rx_data_en_ovrd_o,
  output logic       rx_pll_en_ovrd_o
);
  wdg_state_e state;
  logic poll_tick, hold_done, poll_inc, last_poll;
  logic link_good, stall;

  assign link_good = link_up_i && !in_training_i;
  assign stall     = (ltssm_state_i == RCVR_LOCK_CODE) && !rx_valid_i;

  lt_wdg_span #(.LIMIT(POLL_CYCLES)) u_poll_timer (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .run_i (state == ST_POLL && enable_i),
    .done_o(poll_tick)
  );

  lt_wdg_span #(.LIMIT(HOLD_CYCLES)) u_hold_timer (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .run_i (state == ST_HOLD && enable_i),
    .done_o(hold_done)
  );

  lt_wdg_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_poll_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (state == ST_IDLE),
    .inc_i (poll_inc),
    .last_o(last_poll)
  );

  lt_wdg_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .poll_tick_i(poll_tick),
    .hold_done_i(hold_done),
    .link_good_i(link_good),
    .stall_i    (stall),
    .last_poll_i(last_poll),
    .state_o    (state),
    .poll_inc_o (poll_inc)
  );

  assign link_ok_o         = (state == ST_OK);
  assign link_fail_o       = (state == ST_FAIL);
  assign rx_data_en_ovrd_o = (state == ST_HOLD);
  assign rx_pll_en_ovrd_o  = (state == ST_HOLD);
endmodule

// File: rtl/lt_wdg_chk.sv
module lt_wdg_chk #(
  parameter int unsigned HOLD_CYCLES = 300000,
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic [5:0] ltssm_state_i,
  input logic       link_up_i,
  input logic       in_training_i,
  input logic       rx_valid_i,
  input logic       link_ok_o,
  input logic       link_fail_o,
  input logic       rx_data_en_ovrd_o,
  input logic       rx_pll_en_ovrd_o
);
  logic [HW-1:0] hold_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_run_q <= '0;
    else if (!rx_data_en_ovrd_o) hold_run_q <= '0;
    else if (hold_run_q <= HW'(HOLD_CYCLES)) hold_run_q <= hold_run_q + 1'b1;
  end

  assert_ovrd_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_data_en_ovrd_o == rx_pll_en_ovrd_o);

  assert_ovrd_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_data_en_ovrd_o) |->
      ($past(ltssm_state_i) == 6'h0D && !$past(rx_valid_i) && $past(enable_i)));

  assert_hold_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_run_q <= HW'(HOLD_CYCLES));

  assert_ok_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ok_o) |-> ($past(link_up_i) && !$past(in_training_i)));

  assert_disable_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |->
      !(link_ok_o || link_fail_o || rx_data_en_ovrd_o || rx_pll_en_ovrd_o));

  assert_ok_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_o && enable_i) |=> link_ok_o);

  assert_fail_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_fail_o && enable_i) |=> link_fail_o);

  assert_result_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_ok_o && link_fail_o));
endmodule

bind link_train_watchdog lt_wdg_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .enable_i         (enable_i),
  .ltssm_state_i    (ltssm_state_i),
  .link_up_i        (link_up_i),
  .in_training_i    (in_training_i),
  .rx_valid_i       (rx_valid_i),
  .link_ok_o        (link_ok_o),
  .link_fail_o      (link_fail_o),
  .rx_data_en_ovrd_o(rx_data_en_ovrd_o),
  .rx_pll_en_ovrd_o (rx_pll_en_ovrd_o)
);

// File: tb/tb_link_train_watchdog.sv
`timescale 1ns/1ps
module tb_link_train_watchdog;
  localparam int P = 4;
  localparam int H = 10;
  localparam int M = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [5:0] st = 6'h00;
  logic lu = 1'b0, tr = 1'b0, rv = 1'b0;
  logic ok, fail, ovd, ovp;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  link_train_watchdog #(.POLL_CYCLES(P), .HOLD_CYCLES(H), .MAX_POLLS(M)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .ltssm_state_i(st),
    .link_up_i(lu), .in_training_i(tr), .rx_valid_i(rv),
    .link_ok_o(ok), .link_fail_o(fail),
    .rx_data_en_ovrd_o(ovd), .rx_pll_en_ovrd_o(ovp));

  // {link_up, in_training, rx_valid, state[5:0], expect[1:0]}; expect 0 none, 1 ok, 2 pulse
  localparam logic [10:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b0, 6'h11, 2'd1},
    {1'b1, 1'b0, 1'b0, 6'h0D, 2'd1},
    {1'b1, 1'b1, 1'b0, 6'h0D, 2'd2},
    {1'b1, 1'b1, 1'b1, 6'h0D, 2'd0},
    {1'b0, 1'b0, 1'b0, 6'h0D, 2'd2},
    {1'b0, 1'b0, 1'b1, 6'h0D, 2'd0},
    {1'b0, 1'b0, 1'b0, 6'h0C, 2'd0},
    {1'b0, 1'b0, 1'b0, 6'h0E, 2'd0},
    {1'b0, 1'b0, 1'b0, 6'h2D, 2'd0},
    {1'b0, 1'b1, 1'b0, 6'h1D, 2'd0}
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got {ok,fail,ovd,ovp}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {ok, fail, ovd, ovp};
  endfunction

  task automatic go_idle();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    check("R1 reset", outs(), 4'b0000);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 idle", outs(), 4'b0000);

    // Table: one poll per vector, R3/R4/R6
    foreach (VEC[i]) begin
      {lu, tr, rv, st} = VEC[i][10:2];
      en = 1'b1;
      wait_n(P);
      check("R2 before poll", outs(), 4'b0000);
      wait_n(1);
      case (VEC[i][1:0])
        2'd1: check("R3 link up", outs(), 4'b1000);
        2'd2: check("R4 stall pulse", outs(), 4'b0011);
        default: check("R6 no action", outs(), 4'b0000);
      endcase
      go_idle();
      check("R1 cleared", outs(), 4'b0000);
    end

    // R7: fail after exactly M polls
    {lu, tr, rv, st} = {1'b0, 1'b1, 1'b1, 6'h0D};
    en = 1'b1;
    wait_n(M*P);
    check("R7 not yet failed", outs(), 4'b0000);
    wait_n(1);
    check("R7 failed", outs(), 4'b0100);
    lu = 1'b1; tr = 1'b0;
    wait_n(3*P);
    check("R9 fail sticky", outs(), 4'b0100);
    go_idle();
    check("R9 fail cleared by disable", outs(), 4'b0000);

    // R5/R8: pulse length and uncounted stall poll
    {lu, tr, rv, st} = {1'b0, 1'b0, 1'b0, 6'h0D};
    en = 1'b1;
    wait_n(P+1);
    check("R4 pulse start", outs(), 4'b0011);
    rv = 1'b1;
    begin
      int hi = 1;
      while (ovd === 1'b1 && hi < 4*H) begin
        @(negedge clk);
        if (ovd === 1'b1) hi++;
      end
      check("R5 pulse length", 4'(hi), 4'(H));
    end
    check("R5 overrides cleared", outs(), 4'b0000);
    wait_n(M*P-1);
    check("R8 not failed early", outs(), 4'b0000);
    wait_n(1);
    check("R8 fail after full count", outs(), 4'b0100);
    go_idle();

    // R9: ok sticky
    {lu, tr, rv, st} = {1'b1, 1'b0, 1'b1, 6'h11};
    en = 1'b1;
    wait_n(P+1);
    check("R3 ok", outs(), 4'b1000);
    {lu, tr, rv, st} = {1'b0, 1'b0, 1'b0, 6'h0D};
    wait_n(H+M*P+2);
    check("R9 ok sticky", outs(), 4'b1000);
    go_idle();
    check("R9 ok cleared by disable", outs(), 4'b0000);

    // R1: disable aborts pulse
    en = 1'b1;
    wait_n(P+3);
    check("R4 pulse before abort", outs(), 4'b0011);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R1 abort pulse", outs(), 4'b0000);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule